// File: doc/BRIEF.md
# Emergency Fault Input Manager

This block sits between an external emergency fault pin and the output stage of a motor-drive PWM peripheral. When capture is disabled, which is the state after reset, the pin is handed straight to the processor's non-maskable interrupt line and the peripheral ignores it. When capture is enabled, the pin passes through a two-flop synchroniser, and a selectable polarity decides which level counts as a fault. A recognised fault sets a sticky pending flag. It also drops the output-enable bit, which takes all output drivers to high impedance, and raises an active-high request towards an edge-detecting top-level interrupt controller.

Software reaches the block through a simple write port with two addresses. The control address holds the capture enable and the output enable. The status address holds the pending flag. A clear of the pending flag is refused while the synchronised fault is still active, so a fault that persists cannot be lost. While the flag is set, software cannot turn the outputs back on.

Top module: `fault_guard`

## Requirements
- R1: After reset, capture enable, output enable and the pending flag read 0, `irq_top` is 0 and every bit of `pin_oe` is 0.
- R2: While capture enable (control bit 0) is 0, `core_nmi` equals `fault_pin` in the same cycle and the pending flag is never set.
- R3: While capture enable is 1, `core_nmi` is 0. The fault counts as active when the synchronised pin equals `pol_high`: 1 selects active high and 0 selects active low. Because of two synchroniser stages, a pin change first affects the registered state on the third rising edge after it.
- R4: An active fault while capture is enabled sets the pending flag, which reads at bit 3 of `status_o`, on the next rising edge.
- R5: The edge that captures a fault also clears the output-enable bit (control bit 1), and `pin_oe` is all zeros whenever output enable is 0 or pending is 1.
- R6: `irq_top` equals the pending flag, so each capture after a successful clear gives exactly one rising edge.
- R7: A status write (`wr_addr`=1) with data bit 3 at 0 clears the pending flag only when the synchronised fault is inactive. While the fault is active, the write leaves the flag at 1.
- R8: A status write with data bit 3 at 1 never changes the pending flag.
- R9: A control write (`wr_addr`=0) updates capture enable from data bit 0 at all times. It updates output enable from data bit 1 only while pending is 0; while pending is 1, output enable stays 0.
- R10: While the pending flag stays set, further fault pulses produce no new rising edge on `irq_top`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 1 | Raw external emergency fault input |
| pol_high | input | 1 | Active level of the fault: 1 high, 0 low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 8 | Write data |
| core_nmi | output | 1 | Fault line to the processor core in bypass mode |
| irq_top | output | 1 | Active-high request to the top-level interrupt controller |
| ctrl_o | output | 8 | Control readback: bit 0 capture enable, bit 1 output enable |
| status_o | output | 8 | Status readback: bit 3 pending |
| pin_oe | output | NUM_OUTS | Output-driver enables, 0 means high impedance |

## Verification
The hardest case to reach is a clear attempt that arrives after the raw pin has already gone inactive but while the synchroniser still shows the fault. Such a write must fail, and the same write issued two cycles later must succeed. The stimulus drops the pin and then issues clears on consecutive cycles. A per-cycle reference model that holds the pin history decides which of those clears takes effect. The polarity select is switched to active low partway through the run, and a second fault pulse is applied while the flag is still pending, so that the bench can count rising edges on `irq_top`.

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int NUM_OUTS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fault_pin,
  input  logic                pol_high,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [7:0]          wr_data,
  output logic                core_nmi,
  output logic                irq_top,
  output logic [7:0]          ctrl_o,
  output logic [7:0]          status_o,
  output logic [NUM_OUTS-1:0] pin_oe
);
  localparam int CAP_BIT  = 0;
  localparam int OE_BIT   = 1;
  localparam int PEND_BIT = 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic cap_en, out_en, pending;

  wire fault_act = (sync_q[SYNC_STAGES-1] == pol_high);
  wire hit       = cap_en & fault_act;
  wire ctrl_wr   = wr_en & ~wr_addr;
  wire stat_wr   = wr_en & wr_addr;
  wire clr_ok    = stat_wr & ~wr_data[PEND_BIT] & ~fault_act;
  wire unused_wd = ^{wr_data[7:4], wr_data[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (hit)    pending <= 1'b1;
    else if (clr_ok) pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_en <= 1'b0;
    else if (ctrl_wr) cap_en <= wr_data[CAP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   out_en <= 1'b0;
    else if (hit)                 out_en <= 1'b0;
    else if (ctrl_wr && !pending) out_en <= wr_data[OE_BIT];
  end

  assign core_nmi = cap_en ? 1'b0 : fault_pin;
  assign irq_top  = pending;
  assign ctrl_o   = {6'b0, out_en, cap_en};
  assign status_o = {4'b0, pending, 3'b0};
  assign pin_oe   = {NUM_OUTS{out_en & ~pending}};

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && fault_act) |=> pending);
  assert_oe_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> (!out_en && pin_oe == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && fault_act) |=> pending);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(cap_en && fault_act)) |=> !pending);
  assert_oe_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !out_en);
endmodule

// File: tb/sim_fault_guard.sv
module sim_fault_guard;
  localparam int PERIOD = 10;
  localparam int NO     = 6;
  localparam int SYNC   = 2;
  localparam int LIMIT  = 5000;

  logic clk = 0, rst_n = 0, fault_pin = 0, pol_high = 1;
  logic wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic core_nmi, irq_top;
  logic [7:0] ctrl_o, status_o;
  logic [NO-1:0] pin_oe;

  int tests = 0, fails = 0, irq_rises = 0, cycles = 0;
  bit done = 0, started = 0;
  int hist[$];
  bit m_cap, m_oe, m_pend, prev_irq;

  fault_guard #(.NUM_OUTS(NO), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .pol_high(pol_high),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_nmi(core_nmi), .irq_top(irq_top), .ctrl_o(ctrl_o),
    .status_o(status_o), .pin_oe(pin_oe));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < SYNC; i++) hist.push_back(0);
      m_cap = 0; m_oe = 0; m_pend = 0;
    end else begin
      bit act, seen;
      act = (hist[SYNC-1] == int'(pol_high));
      seen = m_cap && act;
      if (wr_en && !wr_addr) begin
        if (!m_pend) m_oe = wr_data[1];
        m_cap = wr_data[0];
      end
      if (seen) begin
        m_pend = 1;
        m_oe = 0;
      end else if (wr_en && wr_addr && !wr_data[3] && !act) m_pend = 0;
      hist.push_front(int'(fault_pin));
      void'(hist.pop_back());
    end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    if (started) begin
      chk("R9", "capture enable", int'(ctrl_o[0]), int'(m_cap));
      chk("R9", "output enable", int'(ctrl_o[1]), int'(m_oe));
      chk("R4", "pending", int'(status_o[3]), int'(m_pend));
      chk("R6", "irq_top", int'(irq_top), int'(m_pend));
      chk("R5", "pin_oe", int'(pin_oe), (m_oe && !m_pend) ? (1 << NO) - 1 : 0);
      chk("R2", "core_nmi", int'(core_nmi), m_cap ? 0 : int'(fault_pin));
      if (irq_top && !prev_irq) irq_rises++;
      prev_irq = irq_top;
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int r0;
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1", "reset ctrl", int'(ctrl_o), 0);
    chk("R1", "reset status", int'(status_o), 0);
    chk("R1", "reset irq", int'(irq_top), 0);
    chk("R1", "reset pin_oe", int'(pin_oe), 0);

    fault_pin = 1; idle(4);
    chk("R2", "bypass passes pin", int'(core_nmi), 1);
    chk("R2", "bypass no pending", int'(status_o[3]), 0);
    fault_pin = 0; idle(3);

    wr(0, 8'h03); idle(1);
    chk("R9", "outputs enabled", int'(pin_oe), (1 << NO) - 1);
    chk("R3", "core_nmi masked", int'(core_nmi), 0);
    fault_pin = 1;
    idle(2);
    chk("R3", "not yet captured", int'(status_o[3]), 0);
    idle(2);
    chk("R4", "pending set", int'(status_o[3]), 1);
    chk("R5", "output enable cleared", int'(ctrl_o[1]), 0);
    chk("R5", "pins high-Z", int'(pin_oe), 0);
    chk("R6", "irq high", int'(irq_top), 1);

    wr(1, 8'h00); idle(1);
    chk("R7", "clear refused while active", int'(status_o[3]), 1);
    wr(0, 8'h03); idle(1);
    chk("R9", "oe set refused while pending", int'(ctrl_o[1]), 0);

    fault_pin = 0;
    wr(1, 8'h00);
    chk("R7", "clear refused during sync lag", int'(status_o[3]), 1);
    idle(3);
    wr(1, 8'h08); idle(1);
    chk("R8", "write 1 no effect", int'(status_o[3]), 1);
    wr(1, 8'h00); idle(1);
    chk("R7", "clear after release", int'(status_o[3]), 0);
    wr(0, 8'h03); idle(1);
    chk("R9", "oe set after clear", int'(ctrl_o[1]), 1);

    wr(0, 8'h00);
    pol_high = 0; fault_pin = 1; idle(4);
    wr(0, 8'h03); idle(2);
    chk("R3", "active-low idle no capture", int'(status_o[3]), 0);
    fault_pin = 0; idle(4);
    chk("R3", "active-low capture", int'(status_o[3]), 1);
    fault_pin = 1; idle(4);
    r0 = irq_rises;
    fault_pin = 0; idle(4);
    fault_pin = 1; idle(4);
    chk("R10", "no new irq edge while pending", irq_rises, r0);
    wr(1, 8'h00); idle(1);
    chk("R7", "clear inactive low polarity", int'(status_o[3]), 0);
    wr(1, 8'h08); idle(2);
    chk("R8", "write 1 does not set", int'(status_o[3]), 0);
    fault_pin = 0; idle(4);
    chk("R6", "second capture new edge", irq_rises, r0 + 1);
    fault_pin = 1; idle(3);
    wr(1, 8'h00); idle(2);
    finish_run();
  end
endmodule